// File: doc/BRIEF.md
# Event Page Ring Controller

This block keeps track of a ring of 64 event pages held in an external memory. An acquisition side fills pages one after the other. A readout side takes them off in the same order. Each side owns a 6-bit page pointer that wraps around the ring. When the front end signals that an event is complete, the fill pointer moves on. When readout issues a load-next-event command, the drain pointer moves on. The block then reads the header word at the base of the new page through a synchronous RAM read port and keeps the header's word count for the block transfer that follows.

The page under the drain pointer is reserved for readout, so the ring holds at most 63 events. The pointers alone decide when the ring is empty or full. When the ring is full, the block stretches the front end's conversion-busy signal so that no further gate is accepted. Two single-bit answers serve broadcast queries: whether any event is waiting, and whether the current event carries more than its header. A packed status word shows both pointers. A test mode exposes the drain pointer as a random-access memory address and lets it be written.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After reset the drain pointer is 63, the fill pointer is 0, the word count is 0, `wc_ready_o` is 0, `any_evt_o` is 0 and `busy_o` equals `conv_busy_i`.
- R2: `any_evt_o` is 1 exactly when the fill pointer differs from the drain pointer plus one, modulo 64.
- R3: The ring is full when the two pointers are equal. `busy_o` is the OR of `conv_busy_i` and full. Full lasts until the drain pointer moves on or reset is applied.
- R4: An `evt_done_i` pulse while the ring is not full moves the fill pointer on by one, modulo 64, at the next edge. `wr_base_o` is the fill page shifted left by 7.
- R5: An `evt_done_i` pulse while the ring is full is dropped and the fill pointer keeps its value, so at most 63 events are held.
- R6: An accepted `lne_i` asserts `mem_rd_en_o` in the same cycle, with `mem_addr_o` equal to (drain pointer + 1) shifted left by 7. The drain pointer takes that value at the next edge.
- R7: After an accepted `lne_i`, `wc_ready_o` is 0 for one cycle. At the following edge `wc_o` takes bits 5:0 of `mem_rd_data_i` and `wc_ready_o` rises.
- R8: An `lne_i` that arrives during the header fetch cycle is ignored. It neither moves the drain pointer nor starts a memory read.
- R9: `sparse_o` is 1 exactly when `wc_o` is not equal to 1.
- R10: `ptr_status_o` holds the drain page in bits 13:8 and the fill page in bits 5:0. All other bits are 0.
- R11: While `test_mode_i` is 1, `tm_addr_o` is the drain page shifted left by 7; otherwise `tm_addr_o` is 0. A `tm_wr_i` with `test_mode_i` set loads the drain pointer from `tm_ptr_i`, unless an `lne_i` is accepted in the same cycle, in which case the `lne_i` wins. A `tm_wr_i` without `test_mode_i` has no effect.
- R12: Fullness is judged on the state before the edge. When the ring is full and `evt_done_i` and `lne_i` come in the same cycle, the drain pointer moves on and the event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_done_i | input | 1 | Front end finished one event |
| conv_busy_i | input | 1 | Front-end conversion busy |
| lne_i | input | 1 | Load-next-event command |
| test_mode_i | input | 1 | Memory test mode enable |
| tm_wr_i | input | 1 | Write drain pointer (test mode) |
| tm_ptr_i | input | 6 | Page value for test-mode write |
| mem_rd_data_i | input | 16 | Synchronous RAM read data, valid one cycle after the request |
| mem_rd_en_o | output | 1 | RAM read request for a header |
| mem_addr_o | output | 13 | RAM read address |
| wr_base_o | output | 13 | Base address of the page being filled |
| busy_o | output | 1 | Busy interlock, including ring full |
| any_evt_o | output | 1 | Some event is buffered |
| sparse_o | output | 1 | Latched word count is not one |
| wc_o | output | 6 | Latched word count |
| wc_ready_o | output | 1 | Word count loaded |
| ptr_status_o | output | 16 | Packed pointer status |
| tm_addr_o | output | 13 | Drain page as data address in test mode |

## Verification
An event completion and a load-next-event can land in the same cycle, and the interesting case is when this happens while the ring is full. The bench fills the ring with 63 events and shows that a 64th completion is dropped. It then pulses `evt_done_i` and `lne_i` together. The drain pointer must move to page 0, the fill pointer must stay at 63 and full must clear, which shows that fullness is judged before the edge. A test-mode pointer write issued together with a load-next-event is judged the same way: the drain pointer must end one past its old value.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    localparam int PG_PTR_W  = 6;               // 64 pages in the ring
    localparam int PG_WC_W   = 6;               // word-count field in a header
    localparam int PG_LANE_W = 8;               // byte lane per pointer in status
    localparam int PG_STAT_W = 2 * PG_LANE_W;

    typedef logic [PG_PTR_W-1:0] page_t;

    typedef struct packed {
        page_t fill;
        page_t drain;
    } ptr_st_t;

    typedef struct packed {
        logic               pend;
        logic               ready;
        logic [PG_WC_W-1:0] wc;
    } fetch_st_t;
endpackage

// File: rtl/pgbuf_occupancy.sv
module pgbuf_occupancy
    import pgbuf_pkg::*;
(
    input  page_t fill_i,
    input  page_t drain_i,
    output logic  empty_o,
    output logic  full_o
);
    page_t drain_nx;

    always_comb begin
        drain_nx = drain_i + page_t'(1);
        empty_o  = (fill_i == drain_nx);
        full_o   = (fill_i == drain_i);
    end
endmodule

// File: rtl/pgbuf_hdr_fetch.sv
module pgbuf_hdr_fetch
    import pgbuf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               pend_o,
    output logic               ready_o,
    output logic [PG_WC_W-1:0] wc_o
);
    fetch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            st_d.pend  = 1'b0;
            st_d.ready = 1'b1;
            st_d.wc    = rd_data_i[PG_WC_W-1:0];
        end else if (start_i) begin
            st_d.pend  = 1'b1;
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o  = st_q.pend;
    assign ready_o = st_q.ready;
    assign wc_o    = st_q.wc;
endmodule

// File: rtl/pgbuf_status.sv
module pgbuf_status
    import pgbuf_pkg::*;
#(
    parameter int OFS_W = 7
) (
    input  page_t                       fill_i,
    input  page_t                       drain_i,
    input  logic                        test_mode_i,
    output logic [PG_STAT_W-1:0]        status_o,
    output logic [PG_PTR_W+OFS_W-1:0]   wr_base_o,
    output logic [PG_PTR_W+OFS_W-1:0]   tm_addr_o
);
    localparam int ADDR_W = PG_PTR_W + OFS_W;

    page_t lane_src [2];
    assign lane_src[0] = fill_i;
    assign lane_src[1] = drain_i;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign status_o[g*PG_LANE_W +: PG_LANE_W] =
            {{(PG_LANE_W-PG_PTR_W){1'b0}}, lane_src[g]};
    end

    always_comb begin
        wr_base_o = {fill_i, {OFS_W{1'b0}}};
        tm_addr_o = test_mode_i ? {drain_i, {OFS_W{1'b0}}} : {ADDR_W{1'b0}};
    end
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int OFS_W  = 7,
    parameter int DATA_W = 16,
    localparam int ADDR_W = PG_PTR_W + OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_done_i,
    input  logic                 conv_busy_i,
    input  logic                 lne_i,
    input  logic                 test_mode_i,
    input  logic                 tm_wr_i,
    input  logic [PG_PTR_W-1:0]  tm_ptr_i,
    input  logic [DATA_W-1:0]    mem_rd_data_i,
    output logic                 mem_rd_en_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic [ADDR_W-1:0]    wr_base_o,
    output logic                 busy_o,
    output logic                 any_evt_o,
    output logic                 sparse_o,
    output logic [PG_WC_W-1:0]   wc_o,
    output logic                 wc_ready_o,
    output logic [PG_STAT_W-1:0] ptr_status_o,
    output logic [ADDR_W-1:0]    tm_addr_o
);
    ptr_st_t ptr_d, ptr_q;
    logic    empty, full, pend, lne_ok, evt_ok;
    page_t   drain_nx;

    pgbuf_occupancy u_occ (
        .fill_i  (ptr_q.fill),
        .drain_i (ptr_q.drain),
        .empty_o (empty),
        .full_o  (full)
    );

    pgbuf_hdr_fetch #(.DATA_W(DATA_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (lne_ok),
        .rd_data_i (mem_rd_data_i),
        .pend_o    (pend),
        .ready_o   (wc_ready_o),
        .wc_o      (wc_o)
    );

    pgbuf_status #(.OFS_W(OFS_W)) u_stat (
        .fill_i      (ptr_q.fill),
        .drain_i     (ptr_q.drain),
        .test_mode_i (test_mode_i),
        .status_o    (ptr_status_o),
        .wr_base_o   (wr_base_o),
        .tm_addr_o   (tm_addr_o)
    );

    always_comb begin
        ptr_d    = ptr_q;
        drain_nx = ptr_q.drain + page_t'(1);
        lne_ok   = lne_i & ~pend;
        evt_ok   = evt_done_i & ~full;
        if (evt_ok)
            ptr_d.fill = ptr_q.fill + page_t'(1);
        if (lne_ok)
            ptr_d.drain = drain_nx;
        else if (test_mode_i && tm_wr_i)
            ptr_d.drain = tm_ptr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q.fill  <= '0;
            ptr_q.drain <= '1;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign mem_rd_en_o = lne_ok;
    assign mem_addr_o  = {drain_nx, {OFS_W{1'b0}}};
    assign busy_o      = conv_busy_i | full;
    assign any_evt_o   = ~empty;
    assign sparse_o    = (wc_o != PG_WC_W'(1));
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk
    import pgbuf_pkg::*;
#(
    parameter int OFS_W  = 7,
    parameter int DATA_W = 16,
    localparam int ADDR_W = PG_PTR_W + OFS_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 evt_done_i,
    input logic                 lne_i,
    input logic                 test_mode_i,
    input logic                 tm_wr_i,
    input logic [PG_PTR_W-1:0]  tm_ptr_i,
    input logic [DATA_W-1:0]    mem_rd_data_i,
    input logic                 mem_rd_en_o,
    input logic [ADDR_W-1:0]    mem_addr_o,
    input logic                 busy_o,
    input logic                 any_evt_o,
    input logic                 sparse_o,
    input logic [PG_WC_W-1:0]   wc_o,
    input logic                 wc_ready_o,
    input logic [PG_STAT_W-1:0] ptr_status_o,
    input logic [ADDR_W-1:0]    tm_addr_o
);
    page_t fp, dp;
    assign fp = ptr_status_o[PG_PTR_W-1:0];
    assign dp = ptr_status_o[PG_LANE_W +: PG_PTR_W];

    a_r2_any_evt: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt_o == (fp != page_t'(dp + page_t'(1))));
    a_r3_full_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fp == dp) |-> busy_o);
    a_r4_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done_i && fp != dp) |=> fp == page_t'($past(fp) + page_t'(1)));
    a_r5_fill_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done_i && fp == dp) |=> fp == $past(fp));
    a_r6_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> dp == page_t'($past(dp) + page_t'(1)));
    a_r6_hdr_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (mem_addr_o[OFS_W-1:0] == '0 &&
                         mem_addr_o[ADDR_W-1:OFS_W] == page_t'(dp + page_t'(1))));
    a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !wc_ready_o);
    a_r7_wc_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd_en_o, 2) |-> (wc_ready_o && wc_o == $past(mem_rd_data_i[PG_WC_W-1:0])));
    a_r8_one_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);
    a_r9_sparse: assert property (@(posedge clk) disable iff (!rst_n)
        sparse_o == (wc_o != PG_WC_W'(1)));
    a_r10_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_status_o[PG_STAT_W-1:PG_LANE_W+PG_PTR_W] == '0 &&
        ptr_status_o[PG_LANE_W-1:PG_PTR_W] == '0);
    a_r11_tm_addr: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_i ? (tm_addr_o == {dp, {OFS_W{1'b0}}}) : (tm_addr_o == '0));
    a_r11_tm_load: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode_i && tm_wr_i && !mem_rd_en_o) |=> dp == $past(tm_ptr_i));
    a_r12_lne_in_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fp == dp && lne_i && evt_done_i && mem_rd_en_o) |=> (fp == $past(fp) && fp != dp));
endmodule

bind pgbuf_ctrl pgbuf_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_done_i    (evt_done_i),
    .lne_i         (lne_i),
    .test_mode_i   (test_mode_i),
    .tm_wr_i       (tm_wr_i),
    .tm_ptr_i      (tm_ptr_i),
    .mem_rd_data_i (mem_rd_data_i),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_addr_o    (mem_addr_o),
    .busy_o        (busy_o),
    .any_evt_o     (any_evt_o),
    .sparse_o      (sparse_o),
    .wc_o          (wc_o),
    .wc_ready_o    (wc_ready_o),
    .ptr_status_o  (ptr_status_o),
    .tm_addr_o     (tm_addr_o)
);

// File: tb/sim_pgbuf_ctrl.sv
module sim_pgbuf_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_done_i = 1'b0, conv_busy_i = 1'b0, lne_i = 1'b0;
    logic        test_mode_i = 1'b0, tm_wr_i = 1'b0;
    logic [5:0]  tm_ptr_i = '0;
    logic [15:0] mem_rd_data_i = '0;
    logic        mem_rd_en_o, busy_o, any_evt_o, sparse_o, wc_ready_o;
    logic [12:0] mem_addr_o, wr_base_o, tm_addr_o;
    logic [5:0]  wc_o;
    logic [15:0] ptr_status_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pgbuf_ctrl u0 (.*);

    function automatic logic [15:0] hdr(int pg);
        logic [5:0] w;
        w = 6'((pg * 5 + 1) & 63);
        return {4'hC, 6'(pg), w};
    endfunction

    always_ff @(posedge clk)
        if (mem_rd_en_o) mem_rd_data_i <= hdr(int'(mem_addr_o >> 7));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rdp(); return int'(ptr_status_o[13:8]); endfunction
    function automatic int wrp(); return int'(ptr_status_o[5:0]); endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 drain", rdp(), 63);
        chk("R1 fill", wrp(), 0);
        chk("R1 wc", wc_o, 0);
        chk("R1 ready", wc_ready_o, 0);
        chk("R1 any_evt", any_evt_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R9 sparse wc0", sparse_o, 1);
        chk("R11 tm_addr off", tm_addr_o, 0);

        // R4/R3/R2 fill the ring with 63 events
        for (int i = 0; i < 63; i++) begin
            evt_done_i = 1'b1;
            @(negedge clk);
            evt_done_i = 1'b0;
            chk("R4 fill step", wrp(), i + 1);
            chk("R4 wr_base", wr_base_o, (i + 1) << 7);
            chk("R3 full", busy_o, (i == 62) ? 1 : 0);
            chk("R2 any_evt", any_evt_o, 1);
        end
        // R5 extra event dropped while full
        evt_done_i = 1'b1;
        @(negedge clk);
        evt_done_i = 1'b0;
        chk("R5 dropped", wrp(), 63);
        chk("R3 still full", busy_o, 1);

        // R12 event and load-next together while full
        evt_done_i = 1'b1; lne_i = 1'b1;
        #1;
        chk("R6 rd_en", mem_rd_en_o, 1);
        chk("R6 addr", mem_addr_o, 0);
        @(negedge clk);
        evt_done_i = 1'b0;           // lne_i held through the fetch cycle
        chk("R12 drain moved", rdp(), 0);
        chk("R12 fill kept", wrp(), 63);
        chk("R3 full cleared", busy_o, 0);
        #1;
        chk("R8 no second fetch", mem_rd_en_o, 0);
        chk("R7 ready low", wc_ready_o, 0);
        @(negedge clk);
        lne_i = 1'b0;
        chk("R8 drain held", rdp(), 0);
        chk("R7 ready", wc_ready_o, 1);
        chk("R7 wc page0", wc_o, int'(hdr(0) & 16'h3F));
        chk("R9 sparse one", sparse_o, 0);

        // R6/R7/R9/R10/R2 read pages 1..62
        for (int p = 1; p < 63; p++) begin
            lne_i = 1'b1;
            @(negedge clk);
            lne_i = 1'b0;
            @(negedge clk);
            chk("R6 drain", rdp(), p);
            chk("R7 wc", wc_o, int'(hdr(p) & 16'h3F));
            chk("R7 ready", wc_ready_o, 1);
            chk("R9 sparse", sparse_o, (int'(hdr(p) & 16'h3F) != 1) ? 1 : 0);
            chk("R2 any_evt", any_evt_o, (p != 62) ? 1 : 0);
            chk("R10 status", ptr_status_o, (p << 8) | 63);
        end

        // R11 test mode
        tm_wr_i = 1'b1; tm_ptr_i = 6'd10;
        @(negedge clk);
        tm_wr_i = 1'b0;
        chk("R11 write ignored", rdp(), 62);
        test_mode_i = 1'b1;
        #1;
        chk("R11 tm_addr", tm_addr_o, 62 << 7);
        tm_wr_i = 1'b1;
        @(negedge clk);
        tm_wr_i = 1'b0;
        chk("R11 pointer load", rdp(), 10);
        chk("R11 tm_addr new", tm_addr_o, 10 << 7);
        tm_wr_i = 1'b1; tm_ptr_i = 6'd40; lne_i = 1'b1;
        @(negedge clk);
        tm_wr_i = 1'b0; lne_i = 1'b0;
        chk("R11 lne wins", rdp(), 11);
        @(negedge clk);
        chk("R7 wc page11", wc_o, int'(hdr(11) & 16'h3F));
        test_mode_i = 1'b0;
        #1;
        chk("R11 tm_addr off", tm_addr_o, 0);

        // R3 external busy, R4 wrap
        conv_busy_i = 1'b1;
        #1;
        chk("R3 conv busy", busy_o, 1);
        conv_busy_i = 1'b0;
        #1;
        chk("R3 conv idle", busy_o, 0);
        @(negedge clk);
        evt_done_i = 1'b1;
        @(negedge clk);
        evt_done_i = 1'b0;
        chk("R4 wrap", wrp(), 0);
        chk("R2 any_evt after wrap", any_evt_o, 1);

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule